// File: doc/BRIEF.md
# SPI Command Target for a Multiplexed Delta-Sigma Converter

This block is the serial command front of a delta-sigma converter model. A host drives SCLK, an active-low select and DIN. The block returns either the most recent 24-bit conversion or register contents on DOUT, and it drives a data-ready flag. A small bank of byte registers holds the configuration. Three of these registers drive a set of general-purpose pins.

After reset the block streams conversion results. Every frame starts by shifting out the latest result, whatever command the host sends. A decoded register read replaces the remaining result bits with register data once its second byte has arrived. A stop command ends the streaming, and from then on DOUT carries zeros except during register readback. A resume command brings the streaming back. All SPI pins are oversampled on the system clock, so the host's SCLK must be a few system clocks wide in each phase.

Top module: `spi_adc_cmd_target`

## Requirements
- R1: After reset, drdy_n is 1, dout_oe is 0, gpio_oe and gpio_out are 0, register 0 reads 0x01 and all other registers read 0x00.
- R2: While cs_n is high, dout_oe is 0 and SCLK and DIN have no effect on registers or mode. Raising cs_n discards a partial byte and returns the decoder to command state.
- R3: DIN is sampled on the falling SCLK edge. DOUT changes only after a rising SCLK edge. Data goes out MSB first.
- R4: drdy_n goes to 0 in the cycle after conv_valid and goes back to 1 after any rising SCLK edge, even while cs_n is high.
- R5: Out of reset the block is in streaming mode. A frame's first 24 DOUT bits are the latest conv_data captured before cs_n fell.
- R6: A read is byte 0x2A (A = start register) followed by 0x0N. From bit 17 onward, DOUT carries registers A..A+N, one byte each, and the bytes the host sends during this phase are ignored.
- R7: A write is byte 0x4A followed by 0x0N. The next N+1 bytes go to registers A, A+1, and so on. The register address wraps modulo 16.
- R8: A write data byte changes no register while start is low.
- R9: Byte 0x16 stops streaming, so later frames shift zeros except for register readback. Byte 0x14 restarts streaming. Byte 0xFF and other undefined bytes in command position change nothing.
- R10: Register 0x0C marks which pins are general-purpose, register 0x0D bits set to 1 make a pin an input, and register 0x0E holds the pin levels. The outputs are gpio_oe = reg0C & ~reg0D and gpio_out = reg0E & reg0C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Enables register writes while high |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial data from the host |
| dout | output | 1 | Serial data to the host |
| dout_oe | output | 1 | Output enable for dout; low means high impedance |
| drdy_n | output | 1 | Active-low data-ready flag |
| conv_data | input | DATA_W | New conversion result |
| conv_valid | input | 1 | One-cycle strobe that captures conv_data |
| gpio_out | output | NGPIO | Levels driven on the general-purpose pins |
| gpio_oe | output | NGPIO | Per-pin output enables |

## Verification
The bench uses the default values: DATA_W of 24, 16 registers and 8 pins. With these values a single write or read fits in a frame of at most four bytes, so a multi-register burst, an address wrap from register 15 to register 0 and the full 24-bit stream can all be checked within a few frames. The full 8-pin width lets one pair of configuration and direction values produce a mixed enable pattern, with some pins driven, some set as inputs and some left unconfigured.

// File: rtl/spi_adc_cmd_target.sv
module spi_adc_cmd_target #(
  parameter int DATA_W = 24,
  parameter int NREG = 16,
  parameter int NGPIO = 8,
  parameter logic [7:0] REG0_RST = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  output logic              dout,
  output logic              dout_oe,
  output logic              drdy_n,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              conv_valid,
  output logic [NGPIO-1:0]  gpio_out,
  output logic [NGPIO-1:0]  gpio_oe
);
  localparam int AW = $clog2(NREG);
  localparam int PAD = DATA_W - 8;

  typedef enum logic [1:0] {S_CMD, S_ARG, S_WR, S_RD} st_t;

  st_t                      st;
  logic [NREG-1:0][7:0]     regs;
  logic                     sclk_q, cont, wr_cmd, dout_r;
  logic [2:0]               bit_cnt;
  logic [6:0]               sh;
  logic [3:0]               cnt;
  logic [AW-1:0]            addr;
  logic [DATA_W-1:0]        latest, obuf;

  wire             rise      = sclk & ~sclk_q;
  wire             fall      = ~sclk & sclk_q;
  wire [7:0]       byte_in   = {sh, din};
  wire             byte_done = fall & ~cs_n & (bit_cnt == 3'd7);
  wire [AW-1:0]    addr_nxt  = addr + 1'b1;

  assign dout     = dout_r;
  assign dout_oe  = ~cs_n;
  assign gpio_oe  = regs[12][NGPIO-1:0] & ~regs[13][NGPIO-1:0];
  assign gpio_out = regs[14][NGPIO-1:0] & regs[12][NGPIO-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_CMD;
      for (int i = 0; i < NREG; i++) regs[i] <= (i == 0) ? REG0_RST : 8'h00;
      sclk_q <= 1'b0;
      cont <= 1'b1;
      wr_cmd <= 1'b0;
      dout_r <= 1'b0;
      drdy_n <= 1'b1;
      bit_cnt <= '0;
      sh <= '0;
      cnt <= '0;
      addr <= '0;
      latest <= '0;
      obuf <= '0;
    end else begin
      sclk_q <= sclk;
      if (conv_valid) latest <= conv_data;
      if (conv_valid) drdy_n <= 1'b0;
      else if (rise)  drdy_n <= 1'b1;
      if (cs_n) begin
        st <= S_CMD;
        bit_cnt <= '0;
        dout_r <= 1'b0;
        obuf <= cont ? latest : '0;
      end else begin
        if (rise) begin
          dout_r <= obuf[DATA_W-1];
          obuf <= {obuf[DATA_W-2:0], 1'b0};
        end
        if (fall) begin
          bit_cnt <= bit_cnt + 1'b1;
          sh <= {sh[5:0], din};
        end
        if (byte_done) begin
          case (st)
            S_CMD: begin
              if (byte_in[7:4] == 4'h4 || byte_in[7:4] == 4'h2) begin
                addr <= byte_in[AW-1:0];
                wr_cmd <= byte_in[6];
                st <= S_ARG;
              end else if (byte_in == 8'h16) cont <= 1'b0;
              else if (byte_in == 8'h14)     cont <= 1'b1;
            end
            S_ARG: begin
              cnt <= byte_in[3:0];
              if (wr_cmd) st <= S_WR;
              else begin
                st <= S_RD;
                obuf <= {regs[addr], {PAD{1'b0}}};
              end
            end
            S_WR: begin
              if (start) regs[addr] <= byte_in;
              addr <= addr_nxt;
              if (cnt == 4'd0) st <= S_CMD;
              else cnt <= cnt - 1'b1;
            end
            S_RD: begin
              if (cnt == 4'd0) st <= S_CMD;
              else begin
                cnt <= cnt - 1'b1;
                addr <= addr_nxt;
                obuf <= {regs[addr_nxt], {PAD{1'b0}}};
              end
            end
            default: st <= S_CMD;
          endcase
        end
      end
    end
  end

  p_cs_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (st == S_CMD && bit_cnt == 3'd0 && !dout));
  p_dout_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !rise) |=> $stable(dout));
  p_drdy_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_valid |=> !drdy_n);
  p_drdy_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !conv_valid) |=> drdy_n);
  p_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(regs));
  p_cs_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ($stable(regs) && $stable(cont)));
endmodule

// File: tb/tb_spi_adc_cmd_target.sv
module tb_spi_adc_cmd_target;
  logic clk = 0, rst_n = 0, start = 1, cs_n = 1, sclk = 0, din = 0, conv_valid = 0;
  logic [23:0] conv_data = '0;
  logic dout, dout_oe, drdy_n;
  logic [7:0] gpio_out, gpio_oe;
  logic [7:0] txb [4];
  logic [7:0] rxb [4];
  int tests = 0, fails = 0;

  spi_adc_cmd_target dut (.clk, .rst_n, .start, .cs_n, .sclk, .din, .dout, .dout_oe,
    .drdy_n, .conv_data, .conv_valid, .gpio_out, .gpio_oe);

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitx(input logic b, output logic r);
    sclk = 1; din = b; wait_clk(4);
    r = dout;
    sclk = 0; wait_clk(4);
  endtask

  task automatic frame(input int n);
    logic r;
    cs_n = 0; wait_clk(4);
    for (int k = 0; k < n; k++)
      for (int i = 7; i >= 0; i--) begin
        bitx(txb[k][i], r);
        rxb[k][i] = r;
      end
    wait_clk(4); cs_n = 1; wait_clk(4);
  endtask

  task automatic set4(input logic [7:0] a, b, c, d);
    txb[0] = a; txb[1] = b; txb[2] = c; txb[3] = d;
  endtask

  task automatic conv(input logic [23:0] v);
    conv_data = v; conv_valid = 1; wait_clk(1); conv_valid = 0; wait_clk(2);
  endtask

  task automatic t_reset;
    check("R1 drdy_n", drdy_n, 1);
    check("R1 dout_oe", dout_oe, 0);
    check("R1 gpio_oe", gpio_oe, 0);
    check("R1 gpio_out", gpio_out, 0);
  endtask

  task automatic t_drdy;
    logic r;
    conv(24'hA5C3F0);
    check("R4 drdy low", drdy_n, 0);
    bitx(1'b1, r);
    check("R4 drdy high with cs high", drdy_n, 1);
  endtask

  task automatic t_stream;
    set4(8'hFF, 8'hFF, 8'hFF, 8'hFF);
    cs_n = 0; wait_clk(2);
    check("R2 dout_oe in frame", dout_oe, 1);
    cs_n = 1; wait_clk(2);
    frame(3);
    check("R5 R3 stream", {rxb[0], rxb[1], rxb[2]}, 24'hA5C3F0);
  endtask

  task automatic t_rreg_stream;
    set4(8'h20, 8'h00, 8'hFF, 8'hFF);
    frame(3);
    check("R6 R1 read reg0 in stream", {rxb[0], rxb[1], rxb[2]}, 24'hA5C301);
  endtask

  task automatic t_stop;
    set4(8'h16, 8'hFF, 8'hFF, 8'hFF);
    frame(1);
    check("R9 stop frame still streams", rxb[0], 8'hA5);
    set4(8'hFF, 8'hFF, 8'hFF, 8'hFF);
    frame(3);
    check("R9 zeros after stop", {rxb[0], rxb[1], rxb[2]}, 0);
    set4(8'h20, 8'h00, 8'hFF, 8'hFF);
    frame(3);
    check("R9 R6 readback after stop", {rxb[0], rxb[1], rxb[2]}, 24'h000001);
  endtask

  task automatic t_cs_ignore;
    logic r;
    for (int i = 7; i >= 0; i--) bitx(((8'h14 >> i) & 1) != 0, r);
    check("R2 dout_oe cs high", dout_oe, 0);
    set4(8'hFF, 8'hFF, 8'hFF, 8'hFF);
    frame(3);
    check("R2 command ignored while cs high", {rxb[0], rxb[1], rxb[2]}, 0);
  endtask

  task automatic t_partial;
    logic r;
    cs_n = 0; wait_clk(4);
    for (int i = 3; i >= 0; i--) bitx(i == 2, r);
    cs_n = 1; wait_clk(4);
    set4(8'h20, 8'h00, 8'hFF, 8'hFF);
    frame(3);
    check("R2 partial byte discarded", rxb[2], 8'h01);
  endtask

  task automatic t_write_gpio;
    set4(8'h4C, 8'h01, 8'hC3, 8'h41);
    frame(4);
    set4(8'h2C, 8'h01, 8'hFF, 8'hFF);
    frame(4);
    check("R7 R6 burst reg C", rxb[2], 8'hC3);
    check("R7 R6 burst reg D", rxb[3], 8'h41);
    set4(8'h4E, 8'h00, 8'hFF, 8'hFF);
    frame(3);
    check("R10 gpio_oe", gpio_oe, 8'h82);
    check("R10 gpio_out", gpio_out, 8'hC3);
  endtask

  task automatic t_start_gate;
    start = 0;
    set4(8'h43, 8'h00, 8'h55, 8'hFF);
    frame(3);
    start = 1;
    set4(8'h23, 8'h00, 8'hFF, 8'hFF);
    frame(3);
    check("R8 write ignored while start low", rxb[2], 8'h00);
  endtask

  task automatic t_resume;
    set4(8'h14, 8'hFF, 8'hFF, 8'hFF);
    frame(1);
    conv(24'h3C5A96);
    set4(8'hFF, 8'hFF, 8'hFF, 8'hFF);
    frame(3);
    check("R9 R5 resume stream", {rxb[0], rxb[1], rxb[2]}, 24'h3C5A96);
  endtask

  task automatic t_wrap;
    set4(8'h4F, 8'h01, 8'h11, 8'h22);
    frame(4);
    set4(8'h2F, 8'h01, 8'hFF, 8'hFF);
    frame(4);
    check("R7 wrap reg F", rxb[2], 8'h11);
    check("R7 wrap reg 0", rxb[3], 8'h22);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    wait_clk(3); rst_n = 1; wait_clk(3);
    t_reset();
    t_drdy();
    t_stream();
    t_rreg_stream();
    t_stop();
    t_cs_ignore();
    t_partial();
    t_write_gpio();
    t_start_gate();
    t_resume();
    t_wrap();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule